// File: doc/BRIEF.md
# Row-Miss Promotion Decision Unit

This unit sits next to the memory controller of a two-tier main memory, where a small fast tier acts as a cache for a large slow tier. It watches every access that goes to the slow tier, given as a bank number and a row number. For each bank it keeps track of the row that is currently open, so it can tell whether an access hits that open row or misses it. A row that misses often is costly to leave in the slow tier, because a miss there is much slower than in the fast tier. Hits cost about the same in both tiers.

A small fully associative table holds miss counts for the rows touched most recently. Only misses raise a count. When a count reaches the current threshold, the unit raises one request to move that row to the fast tier. A request names one row, which is one migration unit of row data. All counts are cleared at the end of each fixed-length interval, so a row only qualifies if it is reused within one interval. Also at each interval end, the unit compares the latency the interval's migrations saved against what they cost, and moves the threshold one step down or up.

The data copy, device command timing and the fast tier's tag store are handled elsewhere.

Top module: `rowmiss_promoter`

## Requirements
- R1: `acc_hit` is 1 only when `acc_valid` is 1 and `acc_row` equals the open row of bank `acc_bank`. Each valid access makes its row the open row of its bank from the next cycle on. No bank has an open row after reset.
- R2: A hit never changes any count. A miss to a row held in the table adds one to that row's count. A hit to a row not in the table does not allocate an entry.
- R3: A miss to a row not in the table allocates an entry with count 1. The victim is the lowest-indexed free entry. If no entry is free, the victim is the least recently accessed entry, where any access (hit or miss) to a held row makes it the most recent.
- R4: When a miss brings a row's count (after the miss is counted) to a value at or above `cur_thr`, one request for that row is raised on the next cycle. No new request is raised while a request waits with `mig_ready` low. A request may be raised in the same cycle that the pending one is accepted.
- R5: `mig_valid`, `mig_bank` and `mig_row` hold steady until `mig_ready` is sampled high. On acceptance, the table entry of that row is removed, and an access to that row in the same cycle treats the row as untracked.
- R6: The interval is INTERVAL cycles long, counted from reset. In its last cycle, every table entry is removed, and an access in that cycle is not tracked and raises no request. The open rows still update.
- R7: In the last cycle of an interval, the unit takes M as the number of requests accepted in the interval and S as the sum of the counts those requests carried. If S × (SLOW_MISS − FAST_MISS) > M × MIG_COST, the threshold goes down by 1. Otherwise it goes up by 1. The threshold always stays within 1 and 2^CNT_W − 1.
- R8: After reset, `cur_thr` is THR_INIT (4), `mig_valid` is 0 and the table is empty.
- R9: A count stops at 2^CNT_W − 1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A slow-tier access occurs this cycle |
| acc_bank | input | BANK_W | Bank of the access |
| acc_row | input | ROW_W | Row of the access |
| acc_hit | output | 1 | The access hits the bank's open row |
| mig_valid | output | 1 | Promotion request pending |
| mig_ready | input | 1 | Consumer accepts the request |
| mig_bank | output | BANK_W | Bank of the row to promote |
| mig_row | output | ROW_W | Row to promote |
| cur_thr | output | CNT_W | Current promotion threshold |

## Verification
The bench builds the unit with 2 banks, 4 rows per bank, a 4-entry table, 4-bit counts and a 64-cycle interval. With 8 row keys and only 4 entries, LRU eviction, saturating counts and the threshold clamps all come up within a few thousand cycles. The latency gap is 6 and the migration cost is 20, so one accepted request carrying a count of 4 or more lowers the threshold, and a count of 3 or less raises it. The threshold therefore moves in both directions and hits its upper bound. The bench runs its own model of open rows, recency order, counts, the pending request and the interval arithmetic, and compares it with the outputs in every cycle. The stimulus includes walks over all keys, heavy reuse of a few keys, and long stretches with `mig_ready` held low.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

  // Increment that stops at a ceiling instead of wrapping.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] ceil_v);
    logic [31:0] r;
    if (v >= ceil_v) r = ceil_v;
    else             r = v + 32'd1;
    return r;
  endfunction

  // Estimated cycles saved by an interval's promotions.
  function automatic logic [63:0] gain_est(input logic [31:0] miss_sum, input logic [31:0] lat_gap);
    return 64'(miss_sum) * 64'(lat_gap);
  endfunction

  // Estimated cycles spent moving data in an interval.
  function automatic logic [63:0] cost_est(input logic [31:0] moves, input logic [31:0] per_move);
    return 64'(moves) * 64'(per_move);
  endfunction

  // One-step threshold update, clamped to [1, tmax].
  function automatic logic [31:0] adapt_thr(input logic [31:0] thr, input logic [31:0] moves,
                                            input logic [31:0] miss_sum, input logic [31:0] lat_gap,
                                            input logic [31:0] per_move, input logic [31:0] tmax);
    logic [31:0] r;
    if (gain_est(miss_sum, lat_gap) > cost_est(moves, per_move)) begin
      r = (thr > 32'd1) ? thr - 32'd1 : 32'd1;
    end else begin
      r = (thr < tmax) ? thr + 32'd1 : tmax;
    end
    return r;
  endfunction

endpackage

// File: rtl/rmp_open_rows.sv
module rmp_open_rows #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ROW_W-1:0]  acc_row,
  output logic              acc_hit
);
  localparam int unsigned NBANK = 1 << BANK_W;

  logic [NBANK-1:0] open_vld_q;
  logic [ROW_W-1:0] open_row_q [NBANK];

  assign acc_hit = acc_valid && open_vld_q[acc_bank] && (open_row_q[acc_bank] == acc_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_vld_q <= '0;
      for (int b = 0; b < NBANK; b++) open_row_q[b] <= '0;
    end else if (acc_valid) begin
      open_vld_q[acc_bank] <= 1'b1;
      open_row_q[acc_bank] <= acc_row;
    end
  end
endmodule

// File: rtl/rmp_tracker.sv
module rmp_tracker #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned KEY_W   = 16,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_miss,
  input  logic [KEY_W-1:0]   acc_key,
  input  logic               clear,
  input  logic               inval_en,
  input  logic [KEY_W-1:0]   inval_key,
  input  logic [CNT_W-1:0]   thr,
  input  logic               allow,
  output logic               trig,
  output logic [CNT_W-1:0]   trig_cnt,
  output logic [ENTRIES-1:0] vld_vec
);
  import rmp_pkg::*;

  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [ENTRIES-1:0] vld_q, vld_eff, vld_nxt, hit_vec;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q [ENTRIES];
  logic [IDX_W-1:0]   age_q [ENTRIES];

  logic [IDX_W-1:0] match_idx, free_idx, lru_idx, tgt_idx;
  logic             match_any, free_any, active, alloc, bump, touch, counted;
  logic [CNT_W-1:0] new_cnt;

  // Entry removal for an accepted request happens before lookup.
  always_comb begin
    vld_eff = vld_q;
    hit_vec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (inval_en && (key_q[i] == inval_key)) vld_eff[i] = 1'b0;
      hit_vec[i] = vld_eff[i] && (key_q[i] == acc_key);
    end
  end

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    lru_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i])                          match_idx = IDX_W'(i);
      if (!vld_eff[i])                         free_idx  = IDX_W'(i);
      if (age_q[i] == IDX_W'(ENTRIES - 1))     lru_idx   = IDX_W'(i);
    end
  end

  assign match_any = |hit_vec;
  assign free_any  = ~&vld_eff;
  assign tgt_idx   = match_any ? match_idx : (free_any ? free_idx : lru_idx);

  assign active  = acc_valid && !clear;
  assign alloc   = active && acc_miss && !match_any;
  assign bump    = active && acc_miss && match_any;
  assign touch   = active && (match_any || acc_miss);
  assign counted = alloc || bump;

  assign new_cnt = alloc ? CNT_W'(1)
                         : CNT_W'(sat_inc(32'(cnt_q[tgt_idx]), 32'(CNT_MAX)));

  assign trig     = counted && allow && (new_cnt >= thr);
  assign trig_cnt = new_cnt;

  always_comb begin
    vld_nxt = vld_eff;
    if (alloc) vld_nxt[tgt_idx] = 1'b1;
    if (clear) vld_nxt = '0;
  end

  assign vld_vec = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        age_q[i] <= IDX_W'(i);
        key_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      vld_q <= vld_nxt;
      if (alloc)   key_q[tgt_idx] <= acc_key;
      if (counted) cnt_q[tgt_idx] <= new_cnt;
      if (touch) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == tgt_idx)             age_q[i] <= '0;
          else if (age_q[i] < age_q[tgt_idx])   age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rmp_req_reg.sv
module rmp_req_reg #(
  parameter int unsigned KEY_W = 16,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [KEY_W-1:0] trig_key,
  input  logic [CNT_W-1:0] trig_cnt,
  input  logic             mig_ready,
  output logic             mig_valid,
  output logic [KEY_W-1:0] mig_key,
  output logic             accept,
  output logic [CNT_W-1:0] accept_cnt,
  output logic             allow
);
  logic [CNT_W-1:0] cnt_q;

  assign accept     = mig_valid && mig_ready;
  assign allow      = !mig_valid || mig_ready;
  assign accept_cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mig_valid <= 1'b0;
      mig_key   <= '0;
      cnt_q     <= '0;
    end else if (trig) begin
      mig_valid <= 1'b1;
      mig_key   <= trig_key;
      cnt_q     <= trig_cnt;
    end else if (accept) begin
      mig_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rmp_thresh.sv
module rmp_thresh #(
  parameter int unsigned INTERVAL  = 4096,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned THR_INIT  = 4,
  parameter int unsigned SLOW_MISS = 8,
  parameter int unsigned FAST_MISS = 2,
  parameter int unsigned MIG_COST  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] accept_cnt,
  output logic [CNT_W-1:0] thr,
  output logic             iv_end
);
  import rmp_pkg::*;

  localparam int unsigned IV_W    = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int unsigned THR_MAX = (1 << CNT_W) - 1;
  localparam int unsigned LAT_GAP = SLOW_MISS - FAST_MISS;

  logic [IV_W-1:0]  icnt_q;
  logic [31:0]      moves_q, miss_q, moves_tot, miss_tot;
  logic [CNT_W-1:0] thr_nxt;

  assign iv_end    = (icnt_q == IV_W'(INTERVAL - 1));
  assign moves_tot = moves_q + (accept ? 32'd1 : 32'd0);
  assign miss_tot  = miss_q + (accept ? 32'(accept_cnt) : 32'd0);
  assign thr_nxt   = CNT_W'(adapt_thr(32'(thr), moves_tot, miss_tot, 32'(LAT_GAP),
                                      32'(MIG_COST), 32'(THR_MAX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q  <= '0;
      moves_q <= '0;
      miss_q  <= '0;
      thr     <= CNT_W'(THR_INIT);
    end else if (iv_end) begin
      icnt_q  <= '0;
      moves_q <= '0;
      miss_q  <= '0;
      thr     <= thr_nxt;
    end else begin
      icnt_q  <= icnt_q + 1'b1;
      moves_q <= moves_tot;
      miss_q  <= miss_tot;
    end
  end
endmodule

// File: rtl/rowmiss_promoter.sv
module rowmiss_promoter #(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned ROW_W     = 14,
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned INTERVAL  = 4096,
  parameter int unsigned THR_INIT  = 4,
  parameter int unsigned SLOW_MISS = 8,
  parameter int unsigned FAST_MISS = 2,
  parameter int unsigned MIG_COST  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ROW_W-1:0]  acc_row,
  output logic              acc_hit,
  output logic              mig_valid,
  input  logic              mig_ready,
  output logic [BANK_W-1:0] mig_bank,
  output logic [ROW_W-1:0]  mig_row,
  output logic [CNT_W-1:0]  cur_thr
);
  localparam int unsigned KEY_W = BANK_W + ROW_W;

  // Named internal events, visible to the bound checker.
  logic               acc_miss_w, trig_w, allow_w, accept_w, iv_end_w;
  logic [CNT_W-1:0]   trig_cnt_w, accept_cnt_w;
  logic [KEY_W-1:0]   acc_key_w, mig_key_w;
  logic [ENTRIES-1:0] vld_vec_w;

  assign acc_key_w  = {acc_bank, acc_row};
  assign acc_miss_w = acc_valid && !acc_hit;
  assign mig_bank   = mig_key_w[KEY_W-1 -: BANK_W];
  assign mig_row    = mig_key_w[ROW_W-1:0];

  rmp_open_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_bank(acc_bank),
    .acc_row(acc_row), .acc_hit(acc_hit)
  );

  rmp_tracker #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_miss(acc_miss_w),
    .acc_key(acc_key_w), .clear(iv_end_w), .inval_en(accept_w), .inval_key(mig_key_w),
    .thr(cur_thr), .allow(allow_w), .trig(trig_w), .trig_cnt(trig_cnt_w),
    .vld_vec(vld_vec_w)
  );

  rmp_req_reg #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_req (
    .clk(clk), .rst_n(rst_n), .trig(trig_w), .trig_key(acc_key_w), .trig_cnt(trig_cnt_w),
    .mig_ready(mig_ready), .mig_valid(mig_valid), .mig_key(mig_key_w),
    .accept(accept_w), .accept_cnt(accept_cnt_w), .allow(allow_w)
  );

  rmp_thresh #(.INTERVAL(INTERVAL), .CNT_W(CNT_W), .THR_INIT(THR_INIT),
               .SLOW_MISS(SLOW_MISS), .FAST_MISS(FAST_MISS), .MIG_COST(MIG_COST)) u_thr (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .accept_cnt(accept_cnt_w),
    .thr(cur_thr), .iv_end(iv_end_w)
  );
endmodule

// File: rtl/rmp_checks.sv
module rmp_checks #(
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned ROW_W   = 14,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_hit,
  input logic               mig_valid,
  input logic               mig_ready,
  input logic [BANK_W-1:0]  mig_bank,
  input logic [ROW_W-1:0]   mig_row,
  input logic [CNT_W-1:0]   cur_thr,
  input logic               iv_end,
  input logic               trig,
  input logic [ENTRIES-1:0] vld_vec
);
  localparam logic [CNT_W-1:0] TMAX = {CNT_W{1'b1}};

  p_hit_needs_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> acc_valid);

  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (!mig_valid || mig_ready));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_bank) && $stable(mig_row)));

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_valid && mig_ready && !trig) |=> !mig_valid);

  p_interval_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iv_end |=> (vld_vec == '0));

  p_thr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_thr != '0) && (cur_thr <= TMAX));

  p_thr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !iv_end |=> $stable(cur_thr));

  p_thr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iv_end |=> ((cur_thr == $past(cur_thr) + 1'b1) || (cur_thr == $past(cur_thr) - 1'b1)
                || $stable(cur_thr)));
endmodule

bind rowmiss_promoter rmp_checks #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
  .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_bank(mig_bank), .mig_row(mig_row),
  .cur_thr(cur_thr), .iv_end(iv_end_w), .trig(trig_w), .vld_vec(vld_vec_w)
);

// File: tb/rowmiss_promoter_tb.sv
module rowmiss_promoter_tb;
  localparam int BW = 1, RW = 2, NE = 4, CW = 4, IVL = 64;
  localparam int NB = 1 << BW, NR = 1 << RW, CMAX = (1 << CW) - 1;
  localparam int GAP = 6, MCOST = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, mig_ready = 1'b0;
  logic [BW-1:0] acc_bank = '0;
  logic [RW-1:0] acc_row = '0;
  logic acc_hit, mig_valid;
  logic [BW-1:0] mig_bank;
  logic [RW-1:0] mig_row;
  logic [CW-1:0] cur_thr;

  always #5 clk = ~clk;

  rowmiss_promoter #(.BANK_W(BW), .ROW_W(RW), .ENTRIES(NE), .CNT_W(CW), .INTERVAL(IVL),
                     .THR_INIT(4), .SLOW_MISS(8), .FAST_MISS(2), .MIG_COST(MCOST)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_bank(acc_bank), .acc_row(acc_row),
    .acc_hit(acc_hit), .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_bank(mig_bank),
    .mig_row(mig_row), .cur_thr(cur_thr)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Reference state.
  bit m_ov [NB];
  int m_orow [NB];
  bit m_vld [NE];
  int m_key [NE], m_cnt [NE], m_order [NE];
  bit m_pv;
  int m_pkey, m_pcnt, m_thr, m_icnt, m_moves, m_misses;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_ov[i] = 0; m_orow[i] = 0; end
    for (int i = 0; i < NE; i++) begin m_vld[i] = 0; m_key[i] = 0; m_cnt[i] = 0; m_order[i] = i; end
    m_pv = 0; m_pkey = 0; m_pcnt = 0; m_thr = 4; m_icnt = 0; m_moves = 0; m_misses = 0;
  endtask

  task automatic make_recent(input int e);
    int p;
    p = 0;
    for (int i = 0; i < NE; i++) if (m_order[i] == e) p = i;
    for (int i = p; i > 0; i--) m_order[i] = m_order[i-1];
    m_order[0] = e;
  endtask

  task automatic model_step(input bit v, input int b, input int r, input bit rdy);
    int key, slot, tcnt, tm, tx;
    bit hit, miss, ivend, acc, cand, trg;
    key = b * NR + r;
    hit = v && m_ov[b] && (m_orow[b] == r);
    miss = v && !hit;
    ivend = (m_icnt == IVL - 1);
    acc = m_pv && rdy;
    cand = 0; trg = 0; tcnt = 0;
    if (ivend) begin
      for (int e = 0; e < NE; e++) m_vld[e] = 0;
    end else begin
      if (acc) for (int e = 0; e < NE; e++) if (m_vld[e] && m_key[e] == m_pkey) m_vld[e] = 0;
      slot = -1;
      for (int e = 0; e < NE; e++) if (m_vld[e] && m_key[e] == key) slot = e;
      if (v && slot >= 0) begin
        make_recent(slot);
        if (miss) begin
          m_cnt[slot] = (m_cnt[slot] >= CMAX) ? CMAX : m_cnt[slot] + 1;
          tcnt = m_cnt[slot]; cand = 1;
        end
      end else if (miss) begin
        slot = m_order[NE-1];
        for (int e = NE - 1; e >= 0; e--) if (!m_vld[e]) slot = e;
        m_vld[slot] = 1; m_key[slot] = key; m_cnt[slot] = 1;
        make_recent(slot);
        tcnt = 1; cand = 1;
      end
      trg = cand && (tcnt >= m_thr) && (!m_pv || rdy);
    end
    if (ivend) begin
      tm = m_moves + (acc ? 1 : 0);
      tx = m_misses + (acc ? m_pcnt : 0);
      if (tx * GAP > tm * MCOST) m_thr = (m_thr > 1) ? m_thr - 1 : 1;
      else                       m_thr = (m_thr < CMAX) ? m_thr + 1 : CMAX;
      m_moves = 0; m_misses = 0; m_icnt = 0;
    end else begin
      m_moves += acc ? 1 : 0;
      m_misses += acc ? m_pcnt : 0;
      m_icnt++;
    end
    if (trg) begin m_pv = 1; m_pkey = key; m_pcnt = tcnt; end
    else if (acc) m_pv = 0;
    if (v) begin m_ov[b] = 1; m_orow[b] = r; end
  endtask

  // One cycle: drive at the falling edge, compare, then advance at the rising edge.
  task automatic cyc(input bit v, input int b, input int r, input bit rdy);
    bit eh;
    @(negedge clk);
    acc_valid = v; acc_bank = BW'(b); acc_row = RW'(r); mig_ready = rdy;
    #1;
    eh = v && m_ov[b] && (m_orow[b] == r);
    chk(int'(acc_hit), int'(eh), "R1 open-row hit flag");
    chk(int'(mig_valid), int'(m_pv), "R4 request valid (counts per R2 R3 R6 R9)");
    if (m_pv) begin
      chk(int'(mig_bank), m_pkey / NR, "R5 request bank");
      chk(int'(mig_row), m_pkey % NR, "R5 request row");
    end
    chk(int'(cur_thr), m_thr, "R7 threshold");
    @(posedge clk);
    model_step(v, b, r, rdy);
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    acc_valid = 1'b1; acc_bank = '0; acc_row = '0;
    repeat (2) @(negedge clk);
    #1;
    chk(int'(cur_thr), 4, "R8 reset threshold");
    chk(int'(mig_valid), 0, "R8 reset request");
    chk(int'(acc_hit), 0, "R8 no open row after reset");
    @(negedge clk);
    acc_valid = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    model_step(0, 0, 0, 0);

    // Directed: alternate two rows of bank 0; the 7th access is the 4th miss of row 1.
    for (int k = 0; k < 7; k++) cyc(1, 0, (k % 2 == 0) ? 1 : 2, 0);
    @(negedge clk); acc_valid = 0; #1;
    chk(int'(mig_valid), 1, "R4 request after count reaches threshold");
    chk(int'(mig_row), 1, "R4 requested row");
    @(posedge clk); model_step(0, 0, 0, 0);
    cyc(1, 0, 2, 0);             // row 2 reaches 4 but a request is pending
    cyc(0, 0, 0, 0);
    chk(int'(mig_row), 1, "R4 pending request keeps its row");
    cyc(0, 0, 0, 1);             // accepted
    cyc(0, 0, 0, 0);
    chk(int'(mig_valid), 0, "R5 request cleared after acceptance");

    // Directed: repeated hits do not count (R2).
    for (int k = 0; k < 6; k++) cyc(1, 1, 3, 1);

    // Random traffic, random ready.
    for (int k = 0; k < 6000; k++) begin
      lfsr = lfsr_next(lfsr);
      cyc(lfsr[0] | lfsr[1], int'(lfsr[2]), int'(lfsr[4:3]), lfsr[5]);
    end

    // Walk over all 8 keys: every access misses, no row is reused in the table.
    for (int k = 0; k < 1300; k++) cyc(1, (k / NR) % NB, k % NR, 1);
    cyc(0, 0, 0, 1);
    chk(int'(cur_thr), CMAX, "R7 threshold clamps at the top");

    // Heavy reuse of two rows of bank 0, ready always high.
    for (int k = 0; k < 4000; k++) begin
      lfsr = lfsr_next(lfsr);
      cyc(lfsr[0] | lfsr[1] | lfsr[2], 0, k % 2, 1);
    end

    // Long stretches without ready: counts saturate (R9) and requests hold (R5).
    for (int k = 0; k < 4000; k++) begin
      lfsr = lfsr_next(lfsr);
      cyc(1, int'(lfsr[6] & lfsr[7]), k % 2, (k % 64) >= 48);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule